// File: doc/BRIEF.md
# Chip-select gated registered fanout buffer

This block is the clocked command/address stage of a memory module's register. Each rising clock edge samples a data bus together with two active-low chip selects and the clock-enable and termination controls. Each registered value is then driven onto two identical output copies, A and B, so that each copy can serve its own half of the memory load.

The data register loads only on edges where at least one chip select is asserted. On any other edge it keeps its previous value. The chip-select, clock-enable and termination paths load on every edge. An active-low reset clears every register at once, without waiting for a clock, and it overrides the chip-select gating.

Top module: `cmd_fanout_reg`

## Requirements
- R1: While `rst_n` is low, every output (`q_a`, `q_b`, `qcs_n_a`, `qcs_n_b`, `qcke_a`, `qcke_b`, `qodt_a`, `qodt_b`) is 0. The clear takes effect as soon as `rst_n` falls, even in the middle of a clock period.
- R2: When `rst_n` rises, all outputs stay 0 until the first rising clock edge with `rst_n` high loads new values.
- R3: On a rising edge where `dcs_n` and `csr_n` are both 1, `q_a` and `q_b` keep their previous value.
- R4: On a rising edge where `dcs_n` is 0, `q_a` and `q_b` take the value of `d_in` sampled at that edge, whatever the state of `csr_n`.
- R5: On a rising edge where `csr_n` is 0 and `dcs_n` is 1, `q_a` and `q_b` take the value of `d_in` sampled at that edge.
- R6: `qcke_a`/`qcke_b` and `qodt_a`/`qodt_b` take `cke_in` and `odt_in` on every rising edge, whatever the chip-select state.
- R7: `qcs_n_a`/`qcs_n_b` take `dcs_n` on every rising edge, including edges where `csr_n` is 1.
- R8: Each A output equals its B counterpart at all times.
- R9: While `rst_n` is low, a chip select held active across a clock edge does not load data. Reset has priority over the gating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| d_in | input | DATA_W (11) | Command/address data |
| dcs_n | input | 1 | Primary chip select, active low |
| csr_n | input | 1 | Secondary chip select, active low |
| cke_in | input | 1 | Clock-enable control |
| odt_in | input | 1 | Termination control |
| q_a | output | DATA_W | Registered data, copy A |
| q_b | output | DATA_W | Registered data, copy B |
| qcs_n_a | output | 1 | Registered primary chip select, copy A |
| qcs_n_b | output | 1 | Registered primary chip select, copy B |
| qcke_a | output | 1 | Registered clock enable, copy A |
| qcke_b | output | 1 | Registered clock enable, copy B |
| qodt_a | output | 1 | Registered termination, copy A |
| qodt_b | output | 1 | Registered termination, copy B |

## Verification
Every registered output is due exactly one rising edge after its inputs are sampled. A reset clear is due at once, with no edge involved. The bench changes inputs only at falling edges and updates its model at the rising edge. It compares all outputs 1 ns after that rising edge, well before the next falling edge changes the inputs. For the mid-cycle reset checks, the bench reads outputs a fraction of a nanosecond after `rst_n` falls and again just before the next rising edge after release, so the clear and the hold-until-edge behaviour are each seen within the same half period.

// File: rtl/cmd_reg_pkg.sv
package cmd_reg_pkg;

    localparam int unsigned DATA_W_DEF = 11;

    // Control fields that load on every edge
    typedef struct packed {
        logic cs_n;
        logic cke;
        logic odt;
    } ctl_t;

    localparam ctl_t CTL_CLEAR = '{cs_n: 1'b0, cke: 1'b0, odt: 1'b0};

    // Data loads when any chip select is asserted (low)
    function automatic logic load_allowed(input logic pri_n, input logic sec_n);
        return ~(pri_n & sec_n);
    endfunction

endpackage

// File: rtl/cmd_cs_gate.sv
module cmd_cs_gate (
    input  logic dcs_n,
    input  logic csr_n,
    output logic load_en
);
    import cmd_reg_pkg::*;

    always_comb begin
        load_en = load_allowed(dcs_n, csr_n);
    end

endmodule

// File: rtl/cmd_data_stage.sv
module cmd_data_stage #(
    parameter int unsigned WIDTH = cmd_reg_pkg::DATA_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // One enabled flop per bit
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[b] <= 1'b0;
            end else if (load_en) begin
                q[b] <= d[b];
            end
        end
    end

endmodule

// File: rtl/cmd_ctl_stage.sv
module cmd_ctl_stage (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_reg_pkg::ctl_t ctl_d,
    output cmd_reg_pkg::ctl_t ctl_q
);
    import cmd_reg_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_CLEAR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/cmd_fanout_reg.sv
module cmd_fanout_reg #(
    parameter int unsigned DATA_W = cmd_reg_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic              dcs_n,
    input  logic              csr_n,
    input  logic              cke_in,
    input  logic              odt_in,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b,
    output logic              qcs_n_a,
    output logic              qcs_n_b,
    output logic              qcke_a,
    output logic              qcke_b,
    output logic              qodt_a,
    output logic              qodt_b
);
    import cmd_reg_pkg::*;

    logic              load_en;
    logic [DATA_W-1:0] data_q;
    ctl_t              ctl_d;
    ctl_t              ctl_q;

    cmd_cs_gate u_gate (
        .dcs_n   (dcs_n),
        .csr_n   (csr_n),
        .load_en (load_en)
    );

    cmd_data_stage #(.WIDTH(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .d       (d_in),
        .q       (data_q)
    );

    always_comb begin
        ctl_d.cs_n = dcs_n;
        ctl_d.cke  = cke_in;
        ctl_d.odt  = odt_in;
    end

    cmd_ctl_stage u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl_d (ctl_d),
        .ctl_q (ctl_q)
    );

    // Both copies come from the same flop
    assign q_a     = data_q;
    assign q_b     = data_q;
    assign qcs_n_a = ctl_q.cs_n;
    assign qcs_n_b = ctl_q.cs_n;
    assign qcke_a  = ctl_q.cke;
    assign qcke_b  = ctl_q.cke;
    assign qodt_a  = ctl_q.odt;
    assign qodt_b  = ctl_q.odt;

endmodule

// File: rtl/cmd_fanout_reg_chk.sv
module cmd_fanout_reg_chk #(
    parameter int unsigned DATA_W = cmd_reg_pkg::DATA_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] d_in,
    input logic              dcs_n,
    input logic              csr_n,
    input logic              cke_in,
    input logic              odt_in,
    input logic [DATA_W-1:0] q_a,
    input logic [DATA_W-1:0] q_b,
    input logic              qcs_n_a,
    input logic              qcs_n_b,
    input logic              qcke_a,
    input logic              qcke_b,
    input logic              qodt_a,
    input logic              qodt_b
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && qcs_n_a == 1'b0 && qcke_a == 1'b0 && qodt_a == 1'b0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dcs_n && csr_n) |=> $stable(q_a));

    p_load_dcs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dcs_n |=> (q_a == $past(d_in)));

    p_load_csr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dcs_n && !csr_n) |=> (q_a == $past(d_in)));

    p_ctl_ungated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (qcke_a == $past(cke_in) && qodt_a == $past(odt_in)));

    p_cs_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (qcs_n_a == $past(dcs_n)));

    p_copies_r8: assert property (@(posedge clk)
        (q_a == q_b && qcs_n_a == qcs_n_b && qcke_a == qcke_b && qodt_a == qodt_b));

endmodule

bind cmd_fanout_reg cmd_fanout_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_in    (d_in),
    .dcs_n   (dcs_n),
    .csr_n   (csr_n),
    .cke_in  (cke_in),
    .odt_in  (odt_in),
    .q_a     (q_a),
    .q_b     (q_b),
    .qcs_n_a (qcs_n_a),
    .qcs_n_b (qcs_n_b),
    .qcke_a  (qcke_a),
    .qcke_b  (qcke_b),
    .qodt_a  (qodt_a),
    .qodt_b  (qodt_b)
);

// File: tb/cmd_fanout_reg_tb_top.sv
`timescale 1ns/100ps
module cmd_fanout_reg_tb_top;

    localparam int unsigned W = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] d_in = '0;
    logic         dcs_n = 1'b1;
    logic         csr_n = 1'b1;
    logic         cke_in = 1'b0;
    logic         odt_in = 1'b0;
    logic [W-1:0] q_a, q_b;
    logic         qcs_n_a, qcs_n_b, qcke_a, qcke_b, qodt_a, qodt_b;

    int total = 0;
    int bad = 0;

    // model state
    logic [W-1:0] m_q = '0;
    logic         m_cs = 1'b0, m_cke = 1'b0, m_odt = 1'b0;

    always #2.5 clk = ~clk;

    cmd_fanout_reg #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .d_in(d_in), .dcs_n(dcs_n), .csr_n(csr_n),
        .cke_in(cke_in), .odt_in(odt_in), .q_a(q_a), .q_b(q_b),
        .qcs_n_a(qcs_n_a), .qcs_n_b(qcs_n_b), .qcke_a(qcke_a), .qcke_b(qcke_b),
        .qodt_a(qodt_a), .qodt_b(qodt_b)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare every output with the model; tag names the requirement
    task automatic compare(input string tag);
        check(q_a == m_q, {tag, " q_a"}, int'(q_a), int'(m_q));
        check(qcs_n_a == m_cs, {tag, " qcs_n_a"}, int'(qcs_n_a), int'(m_cs));
        check(qcke_a == m_cke && qodt_a == m_odt, {tag, " cke/odt"},
              int'({qcke_a, qodt_a}), int'({m_cke, m_odt}));
        check(q_b == q_a && qcs_n_b == qcs_n_a && qcke_b == qcke_a && qodt_b == qodt_a,
              "R8 copies", int'({q_b, qcs_n_b, qcke_b, qodt_b}),
              int'({q_a, qcs_n_a, qcke_a, qodt_a}));
    endtask

    function automatic bit all_zero();
        return (q_a == '0 && q_b == '0 && !qcs_n_a && !qcs_n_b &&
                !qcke_a && !qcke_b && !qodt_a && !qodt_b);
    endfunction

    // drive at falling edge, model at rising edge, compare 1 ns later
    task automatic step(input logic [W-1:0] d, input logic pcs, input logic scs,
                        input logic cke, input logic odt, input string tag);
        @(negedge clk);
        d_in = d; dcs_n = pcs; csr_n = scs; cke_in = cke; odt_in = odt;
        @(posedge clk);
        if (rst_n) begin
            if (!pcs || !scs) m_q = d;
            m_cs = pcs; m_cke = cke; m_odt = odt;
        end
        #1;
        compare(tag);
    endtask

    task automatic t_reset_state();
        @(posedge clk); #1;
        check(all_zero(), "R1 reset state", int'(q_a), 0);
        @(negedge clk);
        d_in = 11'h5A5; dcs_n = 1'b0; cke_in = 1'b1; odt_in = 1'b1;
        @(posedge clk); #1;
        check(all_zero(), "R9 cs active under reset", int'(q_a), 0);
    endtask

    task automatic t_release();
        @(negedge clk); #0.5;
        rst_n = 1'b1;
        #1.5;
        check(all_zero(), "R2 low until first edge", int'(q_a), 0);
        @(posedge clk);
        m_q = d_in; m_cs = dcs_n; m_cke = cke_in; m_odt = odt_in;
        #1;
        compare("R2 first edge");
    endtask

    task automatic t_capture_dcs();
        step(11'h123, 1'b0, 1'b1, 1'b0, 1'b1, "R4 dcs only");
        step(11'h7FF, 1'b0, 1'b0, 1'b1, 1'b0, "R4 both low");
        step(11'h000, 1'b0, 1'b1, 1'b0, 1'b0, "R4 zero data");
    endtask

    task automatic t_capture_csr();
        step(11'h2AA, 1'b1, 1'b0, 1'b1, 1'b1, "R5 csr only");
        step(11'h555, 1'b1, 1'b0, 1'b0, 1'b1, "R5 csr again");
    endtask

    task automatic t_hold();
        step(11'h3C3, 1'b0, 1'b1, 1'b0, 1'b0, "R4 preload");
        step(11'h444, 1'b1, 1'b1, 1'b0, 1'b0, "R3 hold 1");
        step(11'h7FF, 1'b1, 1'b1, 1'b1, 1'b0, "R3 hold 2");
        check(q_a == 11'h3C3, "R3 held value", int'(q_a), 'h3C3);
    endtask

    task automatic t_ctl_ungated();
        step(11'h001, 1'b1, 1'b1, 1'b1, 1'b1, "R6 idle cke/odt high");
        step(11'h002, 1'b1, 1'b1, 1'b0, 1'b1, "R6 idle cke low");
        step(11'h003, 1'b1, 1'b1, 1'b1, 1'b0, "R6 idle odt low");
    endtask

    task automatic t_cs_follow();
        step(11'h0F0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 dcs low csr high");
        check(qcs_n_a == 1'b0, "R7 qcs low", int'(qcs_n_a), 0);
        step(11'h0F1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 dcs high");
        check(qcs_n_a == 1'b1, "R7 qcs high", int'(qcs_n_a), 1);
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] d;
            logic [3:0]   r;
            d = W'($urandom());
            r = 4'($urandom());
            step(d, r[0], r[1], r[2], r[3], "R3/R4/R5 random");
        end
    endtask

    task automatic t_midcycle_reset();
        step(11'h6B6, 1'b0, 1'b0, 1'b1, 1'b1, "R4 before reset");
        @(posedge clk); #1.3;
        rst_n = 1'b0;
        #0.2;
        check(all_zero(), "R1 mid-cycle clear", int'(q_a), 0);
        m_q = '0; m_cs = 1'b0; m_cke = 1'b0; m_odt = 1'b0;
        @(negedge clk);
        d_in = 11'h1E1; dcs_n = 1'b0; csr_n = 1'b0; cke_in = 1'b1; odt_in = 1'b1;
        @(posedge clk); #1;
        check(all_zero(), "R9 reset over gating", int'(q_a), 0);
        t_release();
    endtask

    initial begin
        t_reset_state();
        t_release();
        t_capture_dcs();
        t_capture_csr();
        t_hold();
        t_ctl_ungated();
        t_cs_follow();
        t_random();
        t_midcycle_reset();
        step(11'h0AB, 1'b1, 1'b1, 1'b0, 1'b0, "R3 hold after reset");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule